// File: doc/BRIEF.md
# Fast Missing-Clock Reference Fail Detector

This block watches the selected reference clock from a faster system clock. The reference reaches it as a one-cycle pulse that has already been synchronized. The expected reference period, counted in system cycles, is an input. The block counts a missing reference cycle each time a window of one and a half periods passes with no edge. When fast switching is enabled and two missing cycles have been counted in a row, it declares the reference failed at once. It does not wait for its slow activity bucket to fill.

A fast failure does four things together. It drives the leaky-bucket activity accumulator straight to its top threshold. It sets a sticky fail flag, which is cleared by writing one. It sends a one-cycle request to switch reference. It moves the lock state machine directly into the second pre-locked state, so the loss-of-lock state is never entered. When fast switching is off, the only failure path is the bucket, which rises by one for each missing cycle and leaks slowly. A bucket failure sends the lock state machine to loss-of-lock. After a fast failure the detector is disarmed until a reference edge is seen again.

Top module: `ref_fastfail_det`

## Requirements
- R1: The block uses the window L = P + floor(P/2), where P is `exp_period`. With `fast_en` = 1 and no further reference edge, `switch_req` is high during exactly the (2L+1)-th rising clock edge after the edge that captured the last reference pulse.
- R2: A reference edge clears both the window timer and the count of missing cycles. A gap shorter than 2L, followed by an edge, therefore causes no failure, and the next failure is timed from that new edge.
- R3: On a fast failure, `bucket_level` equals the top threshold and `act_alarm` is 1 in the same cycle that `switch_req` is high.
- R4: A failure sets `ref_fail_flag`. The flag stays set until `stat_clr` is high at a clock edge. If a failure and a clear occur at the same edge, the flag ends up set.
- R5: A fast failure moves `lock_state` to the second pre-locked state (code 2). It never passes through loss-of-lock (code 4).
- R6: `switch_req` is a one-cycle pulse for each failure event. After a fast failure there is no further fast failure until a reference edge re-arms the detector. A later outage then produces a new pulse.
- R7: With `fast_en` = 0, no failure occurs at 2L+1. Failure comes only when the bucket, which rises by one per missing cycle, reaches its top threshold. At that point `switch_req` pulses, `ref_fail_flag` is set and `lock_state` becomes loss-of-lock (code 4).
- R8: While no missing cycles occur, the bucket drops by one every LEAK_DIV cycles, down to 0. `act_alarm` clears once the level is at or below the low threshold.
- R9: `lock_state` encodings are 1 for pre-locked, 2 for second pre-locked, 3 for locked and 4 for loss-of-lock. From either pre-locked state, LOCK_EDGES reference edges with no missing cycle lead to locked. Loss-of-lock is held for LOL_HOLD cycles and then returns to pre-locked.
- R10: After reset, `switch_req` = 0, `ref_fail_flag` = 0, `bucket_level` = 0, `act_alarm` = 0 and `lock_state` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the reference |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | 1 | One-cycle pulse per synchronized reference edge |
| fast_en | input | 1 | Enables fast missing-clock failure |
| exp_period | input | PW | Expected reference period in system cycles (at least 2) |
| stat_clr | input | 1 | Write-one-to-clear for the fail flag |
| switch_req | output | 1 | One-cycle reference switch request |
| ref_fail_flag | output | 1 | Sticky selected-reference fail flag |
| bucket_level | output | BKT_W | Leaky-bucket activity accumulator |
| act_alarm | output | 1 | Bucket alarm, with hysteresis between the thresholds |
| lock_state | output | 3 | Lock state code |

## Verification
The bench builds the block with an 8-bit period, a bucket top of 4 and low of 1, a leak every 64 cycles, 3 edges to lock and an 8-cycle loss-of-lock dwell. It drives periods of 4 and 8. These small values let the slow bucket reach its top within a few dozen cycles, so the slow path can be compared against the exact fast failure cycle of 2L+1. They also let the bucket drain to empty within a few hundred cycles, and make the lock and dwell transitions visible edge by edge. The same-edge collision between clear and set, and the re-arm after an outage, are both placed on exact cycles.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  typedef enum logic [2:0] {
    LK_PRELOCK  = 3'd1,
    LK_PRELOCK2 = 3'd2,
    LK_LOCKED   = 3'd3,
    LK_LOL      = 3'd4
  } lock_st_e;

  typedef struct packed {
    logic fast;
    logic slow;
  } fail_ev_t;

endpackage

// File: rtl/refmon_gap_timer.sv
module refmon_gap_timer #(
  parameter int PW         = 16,
  parameter int MISS_LIMIT = 2,
  parameter int MW         = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_edge,
  input  logic [PW-1:0] exp_period,
  output logic [MW-1:0] miss_cnt,
  output logic          miss_tick
);
  localparam int LW = PW + 1;

  logic [LW-1:0] limit;
  logic [LW-1:0] gap;
  logic          wrap;

  // window is one and a half expected periods
  always_comb begin
    limit = {1'b0, exp_period} + LW'(exp_period >> 1);
    wrap  = (gap >= limit - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap       <= '0;
      miss_cnt  <= '0;
      miss_tick <= 1'b0;
    end else begin
      miss_tick <= 1'b0;
      if (ref_edge) begin
        gap      <= '0;
        miss_cnt <= '0;
      end else if (wrap) begin
        gap       <= '0;
        miss_tick <= 1'b1;
        if (miss_cnt != MW'(MISS_LIMIT)) miss_cnt <= miss_cnt + 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  a_r2_edge_clears: assert property (@(posedge clk) disable iff (rst)
    ref_edge |=> (miss_cnt == '0));
  a_r1_miss_bound: assert property (@(posedge clk) disable iff (rst)
    miss_cnt <= MW'(MISS_LIMIT));

endmodule

// File: rtl/refmon_leaky_bucket.sv
module refmon_leaky_bucket #(
  parameter int BKT_W    = 8,
  parameter int BKT_HI   = 200,
  parameter int BKT_LO   = 40,
  parameter int LEAK_DIV = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             force_hi,
  output logic [BKT_W-1:0] level,
  output logic             alarm,
  output logic             slow_trip
);
  localparam int LCW = (LEAK_DIV > 2) ? $clog2(LEAK_DIV) : 1;
  localparam logic [BKT_W-1:0] HI_V = BKT_W'(BKT_HI);
  localparam logic [BKT_W-1:0] LO_V = BKT_W'(BKT_LO);

  logic [LCW-1:0]   leak_cnt;
  logic             leak_now;
  logic [BKT_W-1:0] lvl_next;
  logic             alarm_next;

  always_comb begin
    leak_now = (leak_cnt == LCW'(LEAK_DIV - 1));
    lvl_next = level;
    if (force_hi)                          lvl_next = HI_V;
    else if (tick)                         lvl_next = (level >= HI_V) ? HI_V : level + 1'b1;
    else if (leak_now && (level != '0))    lvl_next = level - 1'b1;
    if (force_hi)   alarm_next = 1'b1;
    else if (alarm) alarm_next = (lvl_next > LO_V);
    else            alarm_next = (lvl_next >= HI_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      leak_cnt  <= '0;
      level     <= '0;
      alarm     <= 1'b0;
      slow_trip <= 1'b0;
    end else begin
      leak_cnt  <= leak_now ? '0 : leak_cnt + 1'b1;
      level     <= lvl_next;
      alarm     <= alarm_next;
      slow_trip <= !force_hi && !alarm && alarm_next;
    end
  end

  a_r3_force_top: assert property (@(posedge clk) disable iff (rst)
    force_hi |=> (level == HI_V && alarm));
  a_r8_level_cap: assert property (@(posedge clk) disable iff (rst)
    level <= HI_V);
  a_r7_trip_at_top: assert property (@(posedge clk) disable iff (rst)
    slow_trip |-> (level == HI_V && alarm));

endmodule

// File: rtl/refmon_lock_fsm.sv
module refmon_lock_fsm
  import refmon_pkg::*;
#(
  parameter int LOCK_EDGES = 16,
  parameter int LOL_HOLD   = 1024
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ref_edge,
  input  logic     miss_tick,
  input  logic     fast_fail,
  input  logic     slow_fail,
  output lock_st_e state
);
  localparam int ECW = $clog2(LOCK_EDGES + 1);
  localparam int DCW = $clog2(LOL_HOLD + 1);

  logic [ECW-1:0] ecnt;
  logic [DCW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LK_PRELOCK;
      ecnt  <= '0;
      dcnt  <= '0;
    end else if (fast_fail) begin
      state <= LK_PRELOCK2;   // straight on, loss-of-lock skipped
      ecnt  <= '0;
    end else if (slow_fail) begin
      state <= LK_LOL;
      dcnt  <= '0;
    end else begin
      case (state)
        LK_PRELOCK, LK_PRELOCK2: begin
          if (miss_tick) begin
            ecnt <= '0;
          end else if (ref_edge) begin
            if (ecnt == ECW'(LOCK_EDGES - 1)) begin
              state <= LK_LOCKED;
              ecnt  <= '0;
            end else begin
              ecnt <= ecnt + 1'b1;
            end
          end
        end
        LK_LOCKED: ;
        LK_LOL: begin
          if (dcnt == DCW'(LOL_HOLD - 1)) begin
            state <= LK_PRELOCK;
            dcnt  <= '0;
            ecnt  <= '0;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: state <= LK_PRELOCK;
      endcase
    end
  end

  a_r5_fast_to_pl2: assert property (@(posedge clk) disable iff (rst)
    fast_fail |=> (state == LK_PRELOCK2));
  a_r7_slow_to_lol: assert property (@(posedge clk) disable iff (rst)
    (slow_fail && !fast_fail) |=> (state == LK_LOL));
  a_r9_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
    ((state == LK_PRELOCK || state == LK_PRELOCK2) && !ref_edge) |=> (state != LK_LOCKED));

endmodule

// File: rtl/ref_fastfail_det.sv
module ref_fastfail_det
  import refmon_pkg::*;
#(
  parameter int PW         = 16,
  parameter int MISS_LIMIT = 2,
  parameter int BKT_W      = 8,
  parameter int BKT_HI     = 200,
  parameter int BKT_LO     = 40,
  parameter int LEAK_DIV   = 4096,
  parameter int LOCK_EDGES = 16,
  parameter int LOL_HOLD   = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_edge,
  input  logic             fast_en,
  input  logic [PW-1:0]    exp_period,
  input  logic             stat_clr,
  output logic             switch_req,
  output logic             ref_fail_flag,
  output logic [BKT_W-1:0] bucket_level,
  output logic             act_alarm,
  output logic [2:0]       lock_state
);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  logic [MW-1:0] miss_cnt;
  logic          miss_tick;
  logic          armed;
  logic          slow_trip;
  fail_ev_t      ev;
  lock_st_e      st;

  refmon_gap_timer #(
    .PW(PW), .MISS_LIMIT(MISS_LIMIT), .MW(MW)
  ) u_gap (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .exp_period(exp_period),
    .miss_cnt(miss_cnt), .miss_tick(miss_tick)
  );

  always_comb begin
    ev.fast = fast_en && armed && !ref_edge && (miss_cnt == MW'(MISS_LIMIT));
    ev.slow = slow_trip;
  end

  refmon_leaky_bucket #(
    .BKT_W(BKT_W), .BKT_HI(BKT_HI), .BKT_LO(BKT_LO), .LEAK_DIV(LEAK_DIV)
  ) u_bkt (
    .clk(clk), .rst(rst), .tick(miss_tick), .force_hi(ev.fast),
    .level(bucket_level), .alarm(act_alarm), .slow_trip(slow_trip)
  );

  refmon_lock_fsm #(
    .LOCK_EDGES(LOCK_EDGES), .LOL_HOLD(LOL_HOLD)
  ) u_fsm (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .miss_tick(miss_tick),
    .fast_fail(ev.fast), .slow_fail(ev.slow), .state(st)
  );

  assign lock_state = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed         <= 1'b1;
      switch_req    <= 1'b0;
      ref_fail_flag <= 1'b0;
    end else begin
      if (ev.fast)       armed <= 1'b0;
      else if (ref_edge) armed <= 1'b1;
      switch_req <= ev.fast || ev.slow;
      if (ev.fast || ev.slow) ref_fail_flag <= 1'b1;
      else if (stat_clr)      ref_fail_flag <= 1'b0;
    end
  end

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ref_fail_flag && !stat_clr) |=> ref_fail_flag);
  a_r4_req_sets_flag: assert property (@(posedge clk) disable iff (rst)
    switch_req |-> ref_fail_flag);
  a_r6_one_per_arm: assert property (@(posedge clk) disable iff (rst)
    ev.fast |=> !ev.fast);

endmodule

// File: tb/sim_ref_fastfail_det.sv
module sim_ref_fastfail_det;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8, MISS_LIMIT = 2, BKT_W = 4, BKT_HI = 4, BKT_LO = 1;
  localparam int LEAK_DIV = 64, LOCK_EDGES = 3, LOL_HOLD = 8;

  logic clk = 1'b0;
  logic rst, ref_edge, fast_en, stat_clr;
  logic [PW-1:0] exp_period;
  logic switch_req, ref_fail_flag, act_alarm;
  logic [BKT_W-1:0] bucket_level;
  logic [2:0] lock_state;

  int n_chk = 0, n_bad = 0, per = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_fastfail_det #(
    .PW(PW), .MISS_LIMIT(MISS_LIMIT), .BKT_W(BKT_W), .BKT_HI(BKT_HI), .BKT_LO(BKT_LO),
    .LEAK_DIV(LEAK_DIV), .LOCK_EDGES(LOCK_EDGES), .LOL_HOLD(LOL_HOLD)
  ) u0 (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .fast_en(fast_en), .exp_period(exp_period),
    .stat_clr(stat_clr), .switch_req(switch_req), .ref_fail_flag(ref_fail_flag),
    .bucket_level(bucket_level), .act_alarm(act_alarm), .lock_state(lock_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int win(input int p);
    return p + p / 2;
  endfunction

  task automatic do_reset(input int p, input bit fe);
    rst = 1'b1; ref_edge = 1'b0; stat_clr = 1'b0; fast_en = fe;
    exp_period = PW'(p); per = p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_ref();
    ref_edge = 1'b1;
    @(negedge clk);
    ref_edge = 1'b0;
  endtask

  task automatic run_ref(input int n);
    repeat (n) begin
      repeat (per - 1) @(negedge clk);
      pulse_ref();
    end
  endtask

  // sample once per cycle; index i is the i-th edge after the call
  task automatic watch(input int maxc, input bit stop, output int first,
                       output int npulse, output bit saw_lol);
    first = 0; npulse = 0; saw_lol = 1'b0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (lock_state == 3'd4) saw_lol = 1'b1;
      if (switch_req) begin
        npulse++;
        if (first == 0) first = i;
        if (stop) break;
      end
    end
  endtask

  task automatic t_reset_lock();
    do_reset(4, 1'b0);
    chk("R10 switch_req", int'(switch_req), 0);
    chk("R10 fail flag", int'(ref_fail_flag), 0);
    chk("R10 bucket", int'(bucket_level), 0);
    chk("R10 alarm", int'(act_alarm), 0);
    chk("R10 lock_state", int'(lock_state), 1);
    run_ref(LOCK_EDGES - 1);
    chk("R9 not yet locked", int'(lock_state), 1);
    run_ref(1);
    chk("R9 locked", int'(lock_state), 3);
  endtask

  task automatic t_fast_fail();
    int f, np; bit lol;
    do_reset(4, 1'b1);
    run_ref(4);
    watch(2 * win(per) + 5, 1'b1, f, np, lol);
    chk("R1 fail cycle", f, 2 * win(per) + 1);
    chk("R3 bucket forced", int'(bucket_level), BKT_HI);
    chk("R3 alarm", int'(act_alarm), 1);
    chk("R5 lock_state", int'(lock_state), 2);
    chk("R5 no loss-of-lock", int'(lol), 0);
    chk("R4 flag set", int'(ref_fail_flag), 1);
    @(negedge clk);
    chk("R6 single cycle", int'(switch_req), 0);
    watch(40, 1'b0, f, np, lol);
    chk("R6 no repeat unarmed", np, 0);
    run_ref(LOCK_EDGES);
    chk("R9 relock from pl2", int'(lock_state), 3);
    watch(2 * win(per) + 5, 1'b1, f, np, lol);
    chk("R6 re-armed fail", f, 2 * win(per) + 1);
    run_ref(80);
    chk("R8 bucket drained", int'(bucket_level), 0);
    chk("R8 alarm cleared", int'(act_alarm), 0);
  endtask

  task automatic t_edge_restart();
    int f, np; bit lol;
    do_reset(4, 1'b1);
    run_ref(4);
    repeat (2 * win(per) - 2) @(negedge clk);
    pulse_ref();
    watch(2 * win(per) + 5, 1'b1, f, np, lol);
    chk("R2 timed from new edge", f, 2 * win(per) + 1);
    do_reset(8, 1'b1);
    run_ref(3);
    watch(2 * win(per) + 5, 1'b1, f, np, lol);
    chk("R1 period 8 fail cycle", f, 2 * win(per) + 1);
  endtask

  task automatic t_clear();
    int f, np; bit lol;
    do_reset(4, 1'b1);
    run_ref(4);
    watch(2 * win(per), 1'b0, f, np, lol);
    chk("R4 no early pulse", np, 0);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk("R4 pulse at collision", int'(switch_req), 1);
    chk("R4 set wins over clear", int'(ref_fail_flag), 1);
    repeat (5) @(negedge clk);
    chk("R4 flag sticky", int'(ref_fail_flag), 1);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk("R4 flag cleared", int'(ref_fail_flag), 0);
  endtask

  task automatic t_slow();
    int f, np; bit lol;
    do_reset(4, 1'b0);
    run_ref(4);
    watch(150, 1'b1, f, np, lol);
    chk("R7 no fast fail", int'(f > 2 * win(per) + 1), 1);
    chk("R7 bucket fail seen", int'(f > 0), 1);
    chk("R7 flag set", int'(ref_fail_flag), 1);
    chk("R7 loss-of-lock", int'(lock_state), 4);
    chk("R7 alarm", int'(act_alarm), 1);
    repeat (LOL_HOLD - 1) @(negedge clk);
    chk("R9 dwell held", int'(lock_state), 4);
    @(negedge clk);
    chk("R9 dwell exit", int'(lock_state), 1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; ref_edge = 1'b0; fast_en = 1'b0; stat_clr = 1'b0; exp_period = '0;
    t_reset_lock();
    t_fast_fail();
    t_edge_restart();
    t_clear();
    t_slow();
    summary();
    $finish;
  end

endmodule